// File: doc/BRIEF.md
# Dual-Clock Latched Event Counter Bank

This block holds a small set of event counters. The counters advance in a fast data clock and are read from a separate, slower control clock. Each counter has its own increment strobe in the data domain. When a counter passes its all-ones value it wraps to zero and sets a sticky overflow flag. The data clock may come from a source that is switched at run time, so nothing on the control side ever looks at a live count.

The control side has two one-cycle commands, clear and snapshot. Each command flips a toggle, and that toggle crosses into the data domain through a two-flop synchronizer. An edge detector on the data side turns each flip back into a single-cycle pulse.

- A clear pulse zeroes every live counter and every overflow flag.
- A snapshot pulse copies every live count and flag into holding registers.
- After a snapshot, a completion toggle travels back to the control side and raises a ready flag.
- The control side then reads the held copies through an address-indexed read port with registered outputs.

Top module: `cbank_top`

## Requirements
- R1: After both resets, `snap_ready` is 0 and every read address returns `rd_data` = 0 with `rd_ovf` = 0.
- R2: A live counter adds one on each data clock edge where its `evt_inc` bit is 1. After the all-ones value it wraps to zero.
- R3: A counter's overflow flag is set when the counter wraps. It stays set until a clear, and each snapshot captures it together with the count.
- R4: A `cmd_clear` pulse, once synchronized into the data domain, sets every live count and every overflow flag to zero.
- R5: A `cmd_snap` pulse, once synchronized into the data domain, copies every live count and overflow flag into the holding registers.
- R6: `snap_ready` goes to 1 only after a requested snapshot has been taken. It is 0 in the control cycle that follows any `cmd_snap`.
- R7: `rd_data` and `rd_ovf` show the held entry selected by `rd_addr` one control clock after the address is presented. An address equal to or above the counter count returns zeros.
- R8: Events that occur after a snapshot do not change the read values until the next snapshot.
- R9: If clear and snapshot reach the data domain in the same cycle, the snapshot holds the values from before the clear, and the live counters end at zero.
- R10: A clear leaves the held values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control-side clock |
| ctl_rst | input | 1 | Synchronous active-high reset, control domain |
| dat_clk | input | 1 | Data/update clock |
| dat_rst | input | 1 | Synchronous active-high reset, data domain |
| evt_inc | input | NUM_CNT | Per-counter increment strobes (data domain) |
| cmd_clear | input | 1 | One-cycle clear-all command (control domain) |
| cmd_snap | input | 1 | One-cycle snapshot-all command (control domain) |
| snap_ready | output | 1 | Held values are stable and readable |
| rd_addr | input | ADDR_W | Counter index to read |
| rd_data | output | CNT_W | Held count of the addressed counter |
| rd_ovf | output | 1 | Held overflow flag of the addressed counter |

## Verification
The assertions check the following on every cycle:
- the counter step and its clear;
- the stickiness of the overflow flag;
- that the holding registers change only when a snapshot pulse arrives, and then equal the prior live values;
- that the ready flag drops after a new snapshot command;
- that out-of-range reads return zero.

Some behaviour can only be shown by the bench's scenarios, because it spans the full path across both synchronizers:
- wrap values across long event runs;
- clear and snapshot arriving together, with the snapshot keeping the pre-clear values;
- held values surviving later events and later clears.

// File: rtl/cbank_pkg.sv
package cbank_pkg;
  typedef struct packed {
    logic clear;
    logic snap;
  } cmd_pulse_t;

  function automatic int addr_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cbank_tog_sync.sv
module cbank_tog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tog_in,
  output logic pulse
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], tog_in};
      last  <= chain[STAGES-1];
    end
  end

  assign pulse = chain[STAGES-1] ^ last;
endmodule

// File: rtl/cbank_counter.sv
module cbank_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         ovf
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q   <= '0;
      ovf <= 1'b0;
    end else if (inc) begin
      q <= q + W'(1);
      if (&q) ovf <= 1'b1;
    end
  end

  // R2: step by one (wrapping) when enabled and not cleared
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (!clr && inc) |=> q == $past(q) + W'(1));
  // R3: overflow flag is sticky until a clear
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr) |=> ovf);
  // R3: wrapping sets the flag
  a_r3_wrap_sets: assert property (@(posedge clk) disable iff (rst)
    (!clr && inc && (&q)) |=> ovf);
  // R4: clear empties count and flag
  a_r4_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0 && !ovf));
endmodule

// File: rtl/cbank_snapshot.sv
module cbank_snapshot #(
  parameter int N = 4,
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                take,
  input  logic [N-1:0][W-1:0] live_q,
  input  logic [N-1:0]        live_ovf,
  output logic [N-1:0][W-1:0] hold_q,
  output logic [N-1:0]        hold_ovf,
  output logic                done_tog
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      hold_ovf <= '0;
      done_tog <= 1'b0;
    end else if (take) begin
      hold_q   <= live_q;
      hold_ovf <= live_ovf;
      done_tog <= ~done_tog;
    end
  end

  // R5: a snapshot copies the live state of the cycle it arrives in
  a_r5_capture: assert property (@(posedge clk) disable iff (rst)
    take |=> (hold_q == $past(live_q) && hold_ovf == $past(live_ovf)));
  // R8 / R10: without a snapshot the held state does not move
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !take |=> ($stable(hold_q) && $stable(hold_ovf)));
endmodule

// File: rtl/cbank_readmux.sv
module cbank_readmux #(
  parameter int N  = 4,
  parameter int W  = 32,
  parameter int AW = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       addr,
  input  logic [N-1:0][W-1:0] hold_q,
  input  logic [N-1:0]        hold_ovf,
  output logic [W-1:0]        rd_data,
  output logic                rd_ovf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_ovf  <= 1'b0;
    end else if (int'(addr) < N) begin
      rd_data <= hold_q[addr];
      rd_ovf  <= hold_ovf[addr];
    end else begin
      rd_data <= '0;
      rd_ovf  <= 1'b0;
    end
  end

  // R7: out-of-range addresses read as zero
  a_r7_range: assert property (@(posedge clk) disable iff (rst)
    (int'(addr) >= N) |=> (rd_data == '0 && !rd_ovf));
endmodule

// File: rtl/cbank_top.sv
module cbank_top #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int SYNC_N  = 2,
  localparam int ADDR_W = cbank_pkg::addr_bits(NUM_CNT)
) (
  input  logic               ctl_clk,
  input  logic               ctl_rst,
  input  logic               dat_clk,
  input  logic               dat_rst,
  input  logic [NUM_CNT-1:0] evt_inc,
  input  logic               cmd_clear,
  input  logic               cmd_snap,
  output logic               snap_ready,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [CNT_W-1:0]   rd_data,
  output logic               rd_ovf
);
  import cbank_pkg::*;

  // control-domain command toggles
  logic clr_tog, snap_tog;
  always_ff @(posedge ctl_clk) begin
    if (ctl_rst) begin
      clr_tog  <= 1'b0;
      snap_tog <= 1'b0;
    end else begin
      clr_tog  <= clr_tog ^ cmd_clear;
      snap_tog <= snap_tog ^ cmd_snap;
    end
  end

  // crossing into the data domain
  cmd_pulse_t dat_cmd;
  logic       clr_p, snap_p;

  cbank_tog_sync #(.STAGES(SYNC_N)) u_clr_sync (
    .clk(dat_clk), .rst(dat_rst), .tog_in(clr_tog), .pulse(clr_p));
  cbank_tog_sync #(.STAGES(SYNC_N)) u_snap_sync (
    .clk(dat_clk), .rst(dat_rst), .tog_in(snap_tog), .pulse(snap_p));

  assign dat_cmd.clear = clr_p;
  assign dat_cmd.snap  = snap_p;

  // live counters
  logic [NUM_CNT-1:0][CNT_W-1:0] live_q;
  logic [NUM_CNT-1:0]            live_ovf;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    cbank_counter #(.W(CNT_W)) u_cnt (
      .clk(dat_clk), .rst(dat_rst), .clr(dat_cmd.clear),
      .inc(evt_inc[i]), .q(live_q[i]), .ovf(live_ovf[i]));
  end

  // holding registers
  logic [NUM_CNT-1:0][CNT_W-1:0] hold_q;
  logic [NUM_CNT-1:0]            hold_ovf;
  logic                          done_tog;

  cbank_snapshot #(.N(NUM_CNT), .W(CNT_W)) u_snap (
    .clk(dat_clk), .rst(dat_rst), .take(dat_cmd.snap),
    .live_q(live_q), .live_ovf(live_ovf),
    .hold_q(hold_q), .hold_ovf(hold_ovf), .done_tog(done_tog));

  // completion back to the control domain
  logic done_p;
  cbank_tog_sync #(.STAGES(SYNC_N)) u_done_sync (
    .clk(ctl_clk), .rst(ctl_rst), .tog_in(done_tog), .pulse(done_p));

  always_ff @(posedge ctl_clk) begin
    if (ctl_rst)       snap_ready <= 1'b0;
    else if (cmd_snap) snap_ready <= 1'b0;
    else if (done_p)   snap_ready <= 1'b1;
  end

  // R6: a new request withdraws readiness
  a_r6_drop: assert property (@(posedge ctl_clk) disable iff (ctl_rst)
    cmd_snap |=> !snap_ready);
  // R6: readiness appears only after a returned completion
  a_r6_rise: assert property (@(posedge ctl_clk) disable iff (ctl_rst)
    $rose(snap_ready) |-> $past(done_p));

  // read port
  cbank_readmux #(.N(NUM_CNT), .W(CNT_W), .AW(ADDR_W)) u_rd (
    .clk(ctl_clk), .rst(ctl_rst), .addr(rd_addr),
    .hold_q(hold_q), .hold_ovf(hold_ovf),
    .rd_data(rd_data), .rd_ovf(rd_ovf));
endmodule

// File: tb/cbank_top_test.sv
module cbank_top_test;
  localparam int N  = 3;
  localparam int W  = 8;
  localparam int AW = 2;
  localparam int NV = 6;

  typedef struct packed {
    logic       pre_clear;
    logic [8:0] e0;
    logic [8:0] e1;
    logic [8:0] e2;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 9'd5,   9'd3,   9'd0},
    '{1'b0, 9'd10,  9'd0,   9'd7},
    '{1'b0, 9'd255, 9'd1,   9'd0},
    '{1'b1, 9'd1,   9'd2,   9'd3},
    '{1'b0, 9'd0,   9'd300, 9'd0},
    '{1'b0, 9'd256, 9'd0,   9'd256}
  };

  logic          ctl_clk = 0, dat_clk = 0;
  logic          ctl_rst = 1, dat_rst = 1;
  logic [N-1:0]  evt_inc = '0;
  logic          cmd_clear = 0, cmd_snap = 0;
  logic          snap_ready;
  logic [AW-1:0] rd_addr = '0;
  logic [W-1:0]  rd_data;
  logic          rd_ovf;

  int checks = 0, failures = 0;
  bit finished = 0;
  int acc [N];
  bit aovf [N];

  always #4 ctl_clk = ~ctl_clk;
  always #3 dat_clk = ~dat_clk;

  cbank_top #(.NUM_CNT(N), .CNT_W(W)) uut (
    .ctl_clk(ctl_clk), .ctl_rst(ctl_rst), .dat_clk(dat_clk), .dat_rst(dat_rst),
    .evt_inc(evt_inc), .cmd_clear(cmd_clear), .cmd_snap(cmd_snap),
    .snap_ready(snap_ready), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ovf(rd_ovf));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input int a, input int exp_d, input int exp_o);
    @(negedge ctl_clk) rd_addr = AW'(a);
    @(negedge ctl_clk);
    chk(req, int'(rd_data), exp_d);
    chk(req, int'(rd_ovf), exp_o);
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin acc[i] = 0; aovf[i] = 0; end
  endtask

  task automatic run_events(input int e0, input int e1, input int e2);
    int mx;
    mx = e0 > e1 ? e0 : e1;
    mx = mx > e2 ? mx : e2;
    for (int k = 0; k < mx; k++) begin
      @(negedge dat_clk);
      evt_inc = {k < e2, k < e1, k < e0};
    end
    @(negedge dat_clk) evt_inc = '0;
    acc[0] += e0; acc[1] += e1; acc[2] += e2;
    for (int i = 0; i < N; i++)
      if (acc[i] >= 256) begin aovf[i] = 1; acc[i] %= 256; end
  endtask

  task automatic do_clear();
    @(negedge ctl_clk) cmd_clear = 1;
    @(negedge ctl_clk) cmd_clear = 0;
    repeat (12) @(negedge ctl_clk);
    model_clear();
  endtask

  task automatic do_snap(input string req);
    int n;
    @(negedge ctl_clk) cmd_snap = 1;
    @(negedge ctl_clk) cmd_snap = 0;
    chk("R6 ready low after request", int'(snap_ready), 0);
    n = 0;
    while (!snap_ready && n < 40) begin @(negedge ctl_clk); n++; end
    chk(req, int'(snap_ready), 1);
  endtask

  initial begin
    #150000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (4) @(negedge ctl_clk);
    ctl_rst = 0; dat_rst = 0;
    // R1: reset state
    chk("R1 snap_ready", int'(snap_ready), 0);
    for (int a = 0; a < 4; a++) read_chk("R1 reset read", a, 0, 0);

    // table-driven: R2, R3, R5
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].pre_clear) do_clear();
      run_events(int'(VECS[v].e0), int'(VECS[v].e1), int'(VECS[v].e2));
      do_snap("R6 ready after snapshot");
      for (int i = 0; i < N; i++)
        read_chk($sformatf("R2/R3/R5 vec%0d ctr%0d", v, i), i, acc[i], int'(aovf[i]));
    end

    // R7: out-of-range address
    read_chk("R7 out of range", 3, 0, 0);

    // R8: later events invisible until the next snapshot
    run_events(4, 4, 4);
    read_chk("R8 held after events", 0, 1, 1);
    read_chk("R8 held after events", 1, 46, 1);

    // R10: clear keeps held values; R4: next snapshot shows zeros
    do_clear();
    read_chk("R10 held after clear", 2, 3, 1);
    do_snap("R6 ready after snapshot");
    for (int i = 0; i < N; i++) read_chk("R4 cleared counts", i, 0, 0);

    // R9: clear and snapshot together
    run_events(9, 8, 7);
    @(negedge ctl_clk) begin cmd_clear = 1; cmd_snap = 1; end
    @(negedge ctl_clk) begin cmd_clear = 0; cmd_snap = 0; end
    begin
      int n = 0;
      while (!snap_ready && n < 40) begin @(negedge ctl_clk); n++; end
    end
    chk("R9 ready", int'(snap_ready), 1);
    read_chk("R9 pre-clear value", 0, 9, 0);
    read_chk("R9 pre-clear value", 1, 8, 0);
    read_chk("R9 pre-clear value", 2, 7, 0);
    model_clear();
    do_snap("R6 ready after snapshot");
    for (int i = 0; i < N; i++) read_chk("R9 live cleared", i, 0, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule